// File: doc/BRIEF.md
# Hot-Plug Slot Event Notifier

This block holds the hot-plug part of a downstream port's slot capability. It has two 16-bit registers, slot control and slot status, behind a byte-enabled write port and a combinational read port. Three event inputs set status bits: attention button pressed, presence detect changed and command completed. The block then decides when software must be told about pending hot-plug events.

The block stores the notification decision as a flag. The flag is the logical AND of the hot-plug interrupt enable and "some supported event is both pending and enabled". The flag is evaluated again after every register write, event, and port reset. With message-signalled interrupts off, the level interrupt output follows the flag. With them on, a one-cycle request pulse marks each false-to-true transition of the flag.

A write to slot control counts as a command. It is applied and evaluated first, and then it sets the command-completed status bit, which is evaluated a second time. A write of 1 to the interlock control bit toggles the interlock status bit instead of being stored.

Top module: `hp_slot_notifier`

## Requirements
- R1: The notification condition is true when slot control bit 5 (hot-plug interrupt enable) is 1 and, for at least one of bits 0, 3 and 4, both the slot status bit and the slot control bit at that position are 1. Bit 0 is attention button, bit 3 is presence detect changed, bit 4 is command completed. The stored flag always equals this condition over the stored registers.
- R2: When `msi_en_i` is 0, `intx_o` equals the condition that results from the inputs sampled at each clock edge, and it is valid after that edge. While `msi_en_i` is 1, `intx_o` is 0.
- R3: When `msi_en_i` is 1, `msi_req_o` is high for exactly one cycle after an edge at which the condition goes from false to true. A true-to-false change raises nothing.
- R4: An event or command completion that finds its status bit already set causes no `msi_req_o` pulse and no change on `intx_o`.
- R5: The condition ignores interrupt masking. An event that is pending while its enable is 0 causes a notification at the write that sets the enable.
- R6: Slot status bits 0, 3 and 4 are write-1-to-clear. Status bit 7 (interlock status) cannot be written. All other status bits, and all control bits except 0, 3, 4 and 5, read as 0.
- R7: A slot control write with data bit 11 at 1 and the upper byte enabled toggles status bit 7. Control bit 11 always reads back 0.
- R8: Every slot control write that enables at least one byte sets status bit 4 after the write has been applied and evaluated. If that first evaluation is false and the evaluation with bit 4 set is true, an MSI request is raised, even if the flag was true before the write.
- R9: Byte enable bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. A lane that is not enabled leaves its bits unchanged. A write with no lane enabled has no effect and sets no command completion.
- R10: `port_rst_i` clears status bits 0, 3 and 4, keeps slot control and interlock status, and evaluates the condition again.
- R11: Asserting `rst_n` low clears both registers, the flag and both outputs.
- R12: An event input sets its status bit. An event in the same cycle as a write-1-to-clear of that bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_rst_i | input | 1 | Port reset pulse; clears the event status bits |
| msi_en_i | input | 1 | Selects message-signalled (1) or level (0) interrupt |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 slot control, 1 slot status |
| wr_be_i | input | 2 | Byte enables for the write |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 1 | Read source: 0 slot control, 1 slot status |
| rd_data_o | output | 16 | Read data |
| ev_attn_i | input | 1 | Attention button pressed event |
| ev_pdc_i | input | 1 | Presence detect changed event |
| ev_cmd_i | input | 1 | Command completed event |
| intx_o | output | 1 | Level interrupt |
| msi_req_o | output | 1 | One-cycle message interrupt request |

## Verification
The bench goes after the ordering inside a control write. It sets up a flag that is true before the write, false once the write has cleared an enable, and true again once command completion is set. A design that evaluates only once would miss the request pulse. The bench also:
- re-fires events whose status bit is already set, where a design that pulses on every event would send duplicate requests;
- sets an enable after its event is already pending, where an edge-on-event design would lose the interrupt;
- drives an event in the same cycle as a clear, where a wrong priority drops the event.

Interlock toggling under each byte-enable pattern and port reset with interlock status set make sure that storing the control bit, or clearing too much, shows up at the read port.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W  = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = REG_W / LANE_W;

  // slot control field positions
  localparam int C_ABE  = 0;
  localparam int C_PDCE = 3;
  localparam int C_CCIE = 4;
  localparam int C_HPIE = 5;
  localparam int C_ILK  = 11;

  // slot status field positions (events line up with their enables)
  localparam int S_ABP = 0;
  localparam int S_PDC = 3;
  localparam int S_CC  = 4;
  localparam int S_ILK = 7;

  localparam logic [REG_W-1:0] EV_MASK =
    REG_W'((1 << S_ABP) | (1 << S_PDC) | (1 << S_CC));
  localparam logic [REG_W-1:0] CTL_KEEP =
    REG_W'((1 << C_ABE) | (1 << C_PDCE) | (1 << C_CCIE) | (1 << C_HPIE));

  function automatic logic hp_cond(input logic [REG_W-1:0] ctl,
                                   input logic [REG_W-1:0] sts);
    return ctl[C_HPIE] && (|(ctl & sts & EV_MASK));
  endfunction
endpackage

// File: rtl/hp_slot_ctl_reg.sv
module hp_slot_ctl_reg
  import hp_slot_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int LW = LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctl_i,
  input  logic [W/LW-1:0]    be_i,
  input  logic [W-1:0]       data_i,
  output logic [W-1:0]       ctl_q_o,
  output logic [W-1:0]       ctl_nxt_o,
  output logic               touched_o,
  output logic               ilk_toggle_o
);
  localparam int NL = W / LW;
  localparam int ILK_LANE = C_ILK / LW;

  logic [W-1:0] ctl_q;
  logic [W-1:0] merged;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign merged[l*LW +: LW] = be_i[l] ? data_i[l*LW +: LW] : ctl_q[l*LW +: LW];
  end

  always_comb begin
    touched_o    = wr_ctl_i && (|be_i);
    ilk_toggle_o = wr_ctl_i && be_i[ILK_LANE] && data_i[C_ILK];
    ctl_nxt_o    = touched_o ? (merged & W'(CTL_KEEP)) : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (touched_o) begin
      ctl_q <= ctl_nxt_o;
    end
  end

  assign ctl_q_o = ctl_q;
endmodule

// File: rtl/hp_slot_sts_reg.sv
module hp_slot_sts_reg
  import hp_slot_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int LW = LANE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            port_rst_i,
  input  logic            wr_sts_i,
  input  logic [W/LW-1:0] be_i,
  input  logic [W-1:0]    data_i,
  input  logic            ilk_toggle_i,
  input  logic            cc_set_i,
  input  logic            ev_attn_i,
  input  logic            ev_pdc_i,
  input  logic            ev_cmd_i,
  output logic [W-1:0]    sts_q_o,
  output logic [W-1:0]    sts_mid_o,
  output logic [W-1:0]    sts_fin_o
);
  localparam int NL = W / LW;

  logic [W-1:0] sts_q;
  logic [W-1:0] clr_v;
  logic [W-1:0] set_v;
  logic         upd;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign clr_v[l*LW +: LW] = be_i[l] ? data_i[l*LW +: LW] : '0;
  end

  always_comb begin
    sts_mid_o = sts_q;
    if (port_rst_i) sts_mid_o = sts_mid_o & ~W'(EV_MASK);
    if (wr_sts_i)   sts_mid_o = sts_mid_o & ~(clr_v & W'(EV_MASK));
    if (ilk_toggle_i) sts_mid_o[S_ILK] = ~sts_mid_o[S_ILK];
    set_v         = '0;
    set_v[S_ABP]  = ev_attn_i;
    set_v[S_PDC]  = ev_pdc_i;
    set_v[S_CC]   = ev_cmd_i | cc_set_i;
    sts_fin_o     = sts_mid_o | set_v;
    upd           = (sts_fin_o != sts_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (upd) begin
      sts_q <= sts_fin_o;
    end
  end

  assign sts_q_o = sts_q;
endmodule

// File: rtl/hp_notify_core.sv
module hp_notify_core
  import hp_slot_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         msi_en_i,
  input  logic [W-1:0] ctl_nxt_i,
  input  logic [W-1:0] sts_mid_i,
  input  logic [W-1:0] sts_fin_i,
  output logic         flag_q_o,
  output logic         intx_o,
  output logic         msi_req_o
);
  logic flag_q, intx_q, msi_q;
  logic flag_d, intx_d, msi_d;
  logic cond_mid, cond_fin, rise;

  always_comb begin
    cond_mid = hp_cond(ctl_nxt_i, sts_mid_i);
    cond_fin = hp_cond(ctl_nxt_i, sts_fin_i);
    // a rise either at the write/clear stage or at the event-set stage
    rise     = (!flag_q && cond_mid) || (!cond_mid && cond_fin);
    flag_d   = cond_fin;
    intx_d   = cond_fin && !msi_en_i;
    msi_d    = msi_en_i && rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      intx_q <= 1'b0;
      msi_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      intx_q <= intx_d;
      msi_q  <= msi_d;
    end
  end

  assign flag_q_o  = flag_q;
  assign intx_o    = intx_q;
  assign msi_req_o = msi_q;
endmodule

// File: rtl/hp_slot_notifier.sv
module hp_slot_notifier
  import hp_slot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_rst_i,
  input  logic        msi_en_i,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [1:0]  wr_be_i,
  input  logic [15:0] wr_data_i,
  input  logic        rd_sel_i,
  output logic [15:0] rd_data_o,
  input  logic        ev_attn_i,
  input  logic        ev_pdc_i,
  input  logic        ev_cmd_i,
  output logic        intx_o,
  output logic        msi_req_o
);
  logic [REG_W-1:0] ctl_q, ctl_nxt;
  logic [REG_W-1:0] sts_q, sts_mid, sts_fin;
  logic             ctl_touched, ilk_toggle, flag_q;
  logic             wr_ctl, wr_sts;

  assign wr_ctl = wr_en_i && !wr_sel_i;
  assign wr_sts = wr_en_i &&  wr_sel_i;

  hp_slot_ctl_reg u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctl_i     (wr_ctl),
    .be_i         (wr_be_i),
    .data_i       (wr_data_i),
    .ctl_q_o      (ctl_q),
    .ctl_nxt_o    (ctl_nxt),
    .touched_o    (ctl_touched),
    .ilk_toggle_o (ilk_toggle)
  );

  hp_slot_sts_reg u_sts (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_rst_i   (port_rst_i),
    .wr_sts_i     (wr_sts),
    .be_i         (wr_be_i),
    .data_i       (wr_data_i),
    .ilk_toggle_i (ilk_toggle),
    .cc_set_i     (ctl_touched),
    .ev_attn_i    (ev_attn_i),
    .ev_pdc_i     (ev_pdc_i),
    .ev_cmd_i     (ev_cmd_i),
    .sts_q_o      (sts_q),
    .sts_mid_o    (sts_mid),
    .sts_fin_o    (sts_fin)
  );

  hp_notify_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .msi_en_i  (msi_en_i),
    .ctl_nxt_i (ctl_nxt),
    .sts_mid_i (sts_mid),
    .sts_fin_i (sts_fin),
    .flag_q_o  (flag_q),
    .intx_o    (intx_o),
    .msi_req_o (msi_req_o)
  );

  assign rd_data_o = rd_sel_i ? sts_q : ctl_q;
endmodule

// File: rtl/hp_slot_notifier_chk.sv
module hp_slot_notifier_chk
  import hp_slot_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             port_rst_i,
  input logic             msi_en_i,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [1:0]       wr_be_i,
  input logic             ev_attn_i,
  input logic             ev_pdc_i,
  input logic             ev_cmd_i,
  input logic             intx_o,
  input logic             msi_req_o,
  input logic             flag_q,
  input logic [REG_W-1:0] ctl_q,
  input logic [REG_W-1:0] sts_q
);
  // R1: stored flag agrees with the stored registers
  p_flag_matches_regs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q == hp_cond(ctl_q, sts_q));

  // R2: level output follows the flag when message mode is off
  p_intx_follows_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en_i |=> (intx_o == flag_q));

  p_intx_quiet_in_msi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en_i |=> !intx_o);

  // R3: a request is only raised when the condition is true afterwards
  p_msi_implies_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req_o |-> flag_q);

  // R7: interlock control never stored
  p_ilk_ctl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[C_ILK]);

  // R8: control write leaves command completed set
  p_cc_after_ctl_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_sel_i && (|wr_be_i)) |=> sts_q[S_CC]);

  // R10: port reset alone clears all event status
  p_port_rst_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rst_i && !ev_attn_i && !ev_pdc_i && !ev_cmd_i &&
     !(wr_en_i && !wr_sel_i && (|wr_be_i))) |=> ((sts_q & EV_MASK) == '0));

  // R12: attention event always lands in status
  p_attn_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_attn_i |=> sts_q[S_ABP]);
endmodule

bind hp_slot_notifier hp_slot_notifier_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_rst_i (port_rst_i),
  .msi_en_i   (msi_en_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_be_i    (wr_be_i),
  .ev_attn_i  (ev_attn_i),
  .ev_pdc_i   (ev_pdc_i),
  .ev_cmd_i   (ev_cmd_i),
  .intx_o     (intx_o),
  .msi_req_o  (msi_req_o),
  .flag_q     (flag_q),
  .ctl_q      (ctl_q),
  .sts_q      (sts_q)
);

// File: tb/tb_hp_slot_notifier.sv
`timescale 1ns/1ps
module tb_hp_slot_notifier;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        port_rst_i, msi_en_i, wr_en_i, wr_sel_i, rd_sel_i;
  logic [1:0]  wr_be_i;
  logic [15:0] wr_data_i, rd_data_o;
  logic        ev_attn_i, ev_pdc_i, ev_cmd_i, intx_o, msi_req_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  hp_slot_notifier dut (
    .clk(clk), .rst_n(rst_n), .port_rst_i(port_rst_i), .msi_en_i(msi_en_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_be_i(wr_be_i),
    .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .ev_attn_i(ev_attn_i), .ev_pdc_i(ev_pdc_i), .ev_cmd_i(ev_cmd_i),
    .intx_o(intx_o), .msi_req_o(msi_req_o)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    rd_sel_i = sel;
    #1;
    v = rd_data_o;
  endtask

  task automatic do_wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_be_i = be; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_be_i = '0; wr_data_i = '0;
  endtask

  task automatic do_ev(input logic a, input logic p, input logic c);
    ev_attn_i = a; ev_pdc_i = p; ev_cmd_i = c;
    @(negedge clk);
    ev_attn_i = 1'b0; ev_pdc_i = 1'b0; ev_cmd_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(1'b0, v); check("R11 ctl after reset", v, 16'h0000);
    rd(1'b1, v); check("R11 sts after reset", v, 16'h0000);
    check("R11 intx after reset", {15'd0, intx_o}, 16'd0);
    check("R11 msi after reset", {15'd0, msi_req_o}, 16'd0);
  endtask

  task automatic t_intx_level;
    logic [15:0] v;
    msi_en_i = 1'b0;
    do_wr(1'b0, 2'b11, 16'h0021);
    rd(1'b0, v); check("R6 ctl readback", v, 16'h0021);
    rd(1'b1, v); check("R8 cc set by ctl write", v, 16'h0010);
    check("R1 cc not enabled no intx", {15'd0, intx_o}, 16'd0);
    do_ev(1'b1, 1'b0, 1'b0);
    check("R2 intx asserts", {15'd0, intx_o}, 16'd1);
    rd(1'b1, v); check("R12 attn status", v, 16'h0011);
    do_wr(1'b1, 2'b01, 16'h0001);
    check("R2 intx deasserts on clear", {15'd0, intx_o}, 16'd0);
    rd(1'b1, v); check("R6 w1c attn", v, 16'h0010);
    do_wr(1'b1, 2'b11, 16'hFFFF);
    rd(1'b1, v); check("R6 w1c all, others read 0", v, 16'h0000);
  endtask

  task automatic t_msi_rise;
    msi_en_i = 1'b1;
    do_ev(1'b1, 1'b0, 1'b0);
    check("R3 msi on rise", {15'd0, msi_req_o}, 16'd1);
    check("R2 intx quiet in msi", {15'd0, intx_o}, 16'd0);
    @(negedge clk);
    check("R3 msi one cycle", {15'd0, msi_req_o}, 16'd0);
    do_ev(1'b1, 1'b0, 1'b0);
    check("R4 repeat event no msi", {15'd0, msi_req_o}, 16'd0);
    do_wr(1'b1, 2'b01, 16'h0001);
    check("R3 no msi on fall", {15'd0, msi_req_o}, 16'd0);
    do_ev(1'b1, 1'b0, 1'b0);
    check("R3 msi on second rise", {15'd0, msi_req_o}, 16'd1);
    do_wr(1'b1, 2'b01, 16'h0019);
  endtask

  task automatic t_masked_pending;
    logic [15:0] v;
    msi_en_i = 1'b1;
    do_wr(1'b0, 2'b11, 16'h0020);
    do_wr(1'b1, 2'b01, 16'h0019);
    do_ev(1'b0, 1'b1, 1'b0);
    check("R5 pending while disabled no msi", {15'd0, msi_req_o}, 16'd0);
    rd(1'b1, v); check("R12 pdc status", v, 16'h0008);
    do_wr(1'b0, 2'b11, 16'h0028);
    check("R5 msi when enable set", {15'd0, msi_req_o}, 16'd1);
    do_wr(1'b1, 2'b01, 16'h0019);
    check("R3 clear no msi", {15'd0, msi_req_o}, 16'd0);
  endtask

  task automatic t_cc_order;
    logic [15:0] v;
    msi_en_i = 1'b1;
    do_wr(1'b0, 2'b11, 16'h0021);
    do_wr(1'b1, 2'b01, 16'h0019);
    do_ev(1'b1, 1'b0, 1'b0);
    check("R3 setup rise", {15'd0, msi_req_o}, 16'd1);
    do_wr(1'b0, 2'b11, 16'h0030);
    check("R8 rise via cc after disabling attn", {15'd0, msi_req_o}, 16'd1);
    rd(1'b1, v); check("R8 status after ctl write", v, 16'h0011);
    do_wr(1'b0, 2'b11, 16'h0030);
    check("R4 cc already set no msi", {15'd0, msi_req_o}, 16'd0);
    do_wr(1'b1, 2'b01, 16'h0019);
  endtask

  task automatic t_interlock;
    logic [15:0] v;
    do_wr(1'b0, 2'b10, 16'h0800);
    rd(1'b1, v); check("R7 interlock toggled on", v & 16'h0080, 16'h0080);
    rd(1'b0, v); check("R7 ctl bit11 reads 0, R9 low lane kept", v, 16'h0030);
    do_wr(1'b1, 2'b11, 16'h0080);
    rd(1'b1, v); check("R6 interlock status not writable", v & 16'h0080, 16'h0080);
    do_wr(1'b0, 2'b01, 16'h0830);
    rd(1'b1, v); check("R9 no toggle without upper lane", v & 16'h0080, 16'h0080);
    do_wr(1'b0, 2'b10, 16'h0800);
    rd(1'b1, v); check("R7 interlock toggled off", v & 16'h0080, 16'h0000);
  endtask

  task automatic t_byte_en;
    logic [15:0] v;
    do_wr(1'b0, 2'b10, 16'h003F);
    rd(1'b0, v); check("R9 low lane masked", v, 16'h0030);
    do_wr(1'b1, 2'b01, 16'h0019);
    do_wr(1'b0, 2'b00, 16'h0039);
    rd(1'b1, v); check("R9 no lanes no cc", v, 16'h0000);
    rd(1'b0, v); check("R9 no lanes no write", v, 16'h0030);
  endtask

  task automatic t_port_reset;
    logic [15:0] v;
    msi_en_i = 1'b0;
    do_wr(1'b0, 2'b11, 16'h0029);
    do_ev(1'b1, 1'b1, 1'b0);
    check("R2 intx before port reset", {15'd0, intx_o}, 16'd1);
    do_wr(1'b0, 2'b10, 16'h0800);
    port_rst_i = 1'b1;
    @(negedge clk);
    port_rst_i = 1'b0;
    rd(1'b1, v); check("R10 events cleared, interlock kept", v, 16'h0080);
    rd(1'b0, v); check("R10 ctl kept", v, 16'h0029);
    check("R10 intx drops", {15'd0, intx_o}, 16'd0);
  endtask

  task automatic t_event_vs_clear;
    logic [15:0] v;
    do_ev(1'b1, 1'b0, 1'b0);
    wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_be_i = 2'b01; wr_data_i = 16'h0001;
    ev_attn_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; wr_be_i = '0; wr_data_i = '0; ev_attn_i = 1'b0;
    rd(1'b1, v); check("R12 event beats clear", v & 16'h0001, 16'h0001);
    check("R2 intx stays", {15'd0, intx_o}, 16'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; port_rst_i = 1'b0; msi_en_i = 1'b0; wr_en_i = 1'b0;
    wr_sel_i = 1'b0; wr_be_i = '0; wr_data_i = '0; rd_sel_i = 1'b0;
    ev_attn_i = 1'b0; ev_pdc_i = 1'b0; ev_cmd_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_intx_level();
    t_msi_rise();
    t_masked_pending();
    t_cc_order();
    t_interlock();
    t_byte_en();
    t_port_reset();
    t_event_vs_clear();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule